// File: doc/BRIEF.md
# Variable-Length Instruction Fetch Splitter

This block sits at the end of the fetch stage of a small 32-bit processor with a variable-length instruction encoding. Each cycle it may be given a six-byte window of instruction bytes, read from memory starting at the current program counter, together with that program counter. From the leading byte it takes the operation class and the function code. From the operation class it decides whether a register-specifier byte follows and whether a four-byte constant is carried. It then pulls out the two register identifiers and the constant, and it computes the address of the next sequential instruction.

All results are registered and appear together one clock after the window is offered, marked by a one-cycle valid strobe. When no window is offered, the result registers keep their contents. Operation classes outside the defined set raise an invalid-instruction flag. Such an instruction is treated as one byte long and carries no fields. The block does not model instruction memory, register-file reads or the choice of the next program counter.

Top module: `ifetch_splitter`

## Requirements
- R1: When `in_valid` is high at a rising clock edge, `out_valid` is high for the following cycle, and all other outputs show that window's results in the same cycle. When `in_valid` is low at an edge, `out_valid` is low after that edge.
- R2: `out_op` equals bits [7:4] of byte 0 and `out_fn` equals bits [3:0] of byte 0. Byte k of the window is `in_bytes[8k+7:8k]`.
- R3: Operation classes 0x2, 0x3, 0x4, 0x5, 0x6, 0xA and 0xB carry a register byte, which is byte 1. For these classes `out_has_reg` is 1, `out_ra` is byte 1 bits [7:4] and `out_rb` is byte 1 bits [3:0]. For every other class `out_has_reg` is 0 and both register outputs are 0xF.
- R4: Operation classes 0x7 and 0x8 carry a constant but no register byte. For these classes `out_has_const` is 1 and `out_const` is bytes 1 to 4 assembled little-endian, with byte 1 as the least significant byte.
- R5: Operation classes 0x3, 0x4 and 0x5 carry both a register byte and a constant. For these classes `out_has_const` is 1 and `out_const` is bytes 2 to 5 assembled little-endian, with byte 2 as the least significant byte.
- R6: For every class without a constant, `out_has_const` is 0 and `out_const` is 0.
- R7: `out_len` is 1 for classes 0x0, 0x1 and 0x9, 2 for classes 0x2, 0x6, 0xA and 0xB, 5 for classes 0x7 and 0x8, and 6 for classes 0x3, 0x4 and 0x5. `out_next_pc` equals `in_pc + out_len` modulo 2^32.
- R8: Classes 0xC to 0xF set `out_bad` to 1, with length 1, no register byte and no constant. All other classes set `out_bad` to 0.
- R9: When `in_valid` is low, every result output keeps the value it had, whatever is on `in_bytes` and `in_pc`.
- R10: Synchronous reset `rst` sets `out_valid`, `out_bad`, `out_has_reg`, `out_has_const`, `out_op`, `out_fn`, `out_len`, `out_const` and `out_next_pc` to 0, and sets `out_ra` and `out_rb` to 0xF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A window is offered this cycle |
| in_pc | input | 32 | Address of byte 0 of the window |
| in_bytes | input | 48 | Six instruction bytes, byte 0 in bits [7:0] |
| out_valid | output | 1 | One-cycle strobe: results are new |
| out_op | output | 4 | Operation class |
| out_fn | output | 4 | Function code |
| out_ra | output | 4 | First register identifier, 0xF if none |
| out_rb | output | 4 | Second register identifier, 0xF if none |
| out_const | output | 32 | Constant, 0 if none |
| out_next_pc | output | 32 | Fall-through address |
| out_len | output | 3 | Instruction length in bytes |
| out_has_reg | output | 1 | A register byte is present |
| out_has_const | output | 1 | A constant is present |
| out_bad | output | 1 | Operation class is not defined |

## Verification
Every result is due exactly one rising edge after its window is offered. There is one register stage from input to output, so the bench drives each window on a falling edge and compares all fields a short time after the next rising edge, before the following window is driven. The hold checks drive a different window with `in_valid` low and compare, after that edge, with the values from the last accepted window. The reset values are compared after reset is released and before any window has been accepted.

// File: rtl/fsplit_pkg.sv
package fsplit_pkg;
  localparam int LEN_W = 3;
  localparam logic [3:0] REG_NONE = 4'hF;

  typedef enum logic [3:0] {
    OP_HALT  = 4'h0,
    OP_NOP   = 4'h1,
    OP_RRMOV = 4'h2,
    OP_IRMOV = 4'h3,
    OP_RMMOV = 4'h4,
    OP_MRMOV = 4'h5,
    OP_ALU   = 4'h6,
    OP_JCC   = 4'h7,
    OP_CALL  = 4'h8,
    OP_RET   = 4'h9,
    OP_PUSH  = 4'hA,
    OP_POP   = 4'hB
  } op_e;

  typedef struct packed {
    logic             has_reg;
    logic             has_const;
    logic             bad;
    logic [LEN_W-1:0] len;
  } shape_t;
endpackage

// File: rtl/fsplit_shape.sv
module fsplit_shape
  import fsplit_pkg::*;
#(
  parameter int CONST_BYTES = 4
) (
  input  logic [3:0] op,
  output shape_t     shape
);
  localparam logic [LEN_W-1:0] L_CONST = LEN_W'(CONST_BYTES);

  logic hr, hc, bad;

  always_comb begin
    hr  = 1'b0;
    hc  = 1'b0;
    bad = 1'b0;
    case (op)
      OP_HALT, OP_NOP, OP_RET: ;
      OP_RRMOV, OP_ALU, OP_PUSH, OP_POP: hr = 1'b1;
      OP_IRMOV, OP_RMMOV, OP_MRMOV: begin
        hr = 1'b1;
        hc = 1'b1;
      end
      OP_JCC, OP_CALL: hc = 1'b1;
      default: bad = 1'b1;
    endcase
  end

  always_comb begin
    shape.has_reg   = hr;
    shape.has_const = hc;
    shape.bad       = bad;
    shape.len       = LEN_W'(1) + LEN_W'(hr) + (hc ? L_CONST : '0);
  end
endmodule

// File: rtl/fsplit_fields.sv
module fsplit_fields
  import fsplit_pkg::*;
#(
  parameter int WIN_BYTES   = 6,
  parameter int CONST_BYTES = 4
) (
  input  logic [WIN_BYTES*8-1:0]   window,
  input  logic                     has_reg,
  input  logic                     has_const,
  output logic [3:0]               ra,
  output logic [3:0]               rb,
  output logic [CONST_BYTES*8-1:0] cval
);
  localparam int C_W = CONST_BYTES * 8;

  logic [7:0] spec;
  assign spec = window[15:8];
  assign ra   = has_reg ? spec[7:4] : REG_NONE;
  assign rb   = has_reg ? spec[3:0] : REG_NONE;

  logic [C_W-1:0] raw;

  // The constant starts one byte later when a register byte sits in front of it.
  for (genvar k = 0; k < CONST_BYTES; k++) begin : g_cbyte
    assign raw[k*8 +: 8] = has_reg ? window[(k+2)*8 +: 8]
                                   : window[(k+1)*8 +: 8];
  end

  assign cval = has_const ? raw : '0;
endmodule

// File: rtl/fsplit_nextpc.sv
module fsplit_nextpc
  import fsplit_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] pc,
  input  logic [LEN_W-1:0]  len,
  output logic [ADDR_W-1:0] next_pc
);
  assign next_pc = pc + ADDR_W'(len);
endmodule

// File: rtl/ifetch_splitter.sv
module ifetch_splitter
  import fsplit_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int WIN_BYTES   = 6,
  parameter int CONST_BYTES = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     in_valid,
  input  logic [ADDR_W-1:0]        in_pc,
  input  logic [WIN_BYTES*8-1:0]   in_bytes,
  output logic                     out_valid,
  output logic [3:0]               out_op,
  output logic [3:0]               out_fn,
  output logic [3:0]               out_ra,
  output logic [3:0]               out_rb,
  output logic [CONST_BYTES*8-1:0] out_const,
  output logic [ADDR_W-1:0]        out_next_pc,
  output logic [LEN_W-1:0]         out_len,
  output logic                     out_has_reg,
  output logic                     out_has_const,
  output logic                     out_bad
);
  localparam int C_W = CONST_BYTES * 8;

  shape_t            shape;
  logic [3:0]        ra_c, rb_c;
  logic [C_W-1:0]    c_c;
  logic [ADDR_W-1:0] npc_c;

  fsplit_shape #(.CONST_BYTES(CONST_BYTES)) u_shape (
    .op    (in_bytes[7:4]),
    .shape (shape)
  );

  fsplit_fields #(.WIN_BYTES(WIN_BYTES), .CONST_BYTES(CONST_BYTES)) u_fields (
    .window    (in_bytes),
    .has_reg   (shape.has_reg),
    .has_const (shape.has_const),
    .ra        (ra_c),
    .rb        (rb_c),
    .cval      (c_c)
  );

  fsplit_nextpc #(.ADDR_W(ADDR_W)) u_npc (
    .pc      (in_pc),
    .len     (shape.len),
    .next_pc (npc_c)
  );

  always_ff @(posedge clk) begin
    if (rst) out_valid <= 1'b0;
    else     out_valid <= in_valid;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_op        <= '0;
      out_fn        <= '0;
      out_ra        <= REG_NONE;
      out_rb        <= REG_NONE;
      out_const     <= '0;
      out_next_pc   <= '0;
      out_len       <= '0;
      out_has_reg   <= 1'b0;
      out_has_const <= 1'b0;
      out_bad       <= 1'b0;
    end else if (in_valid) begin
      out_op        <= in_bytes[7:4];
      out_fn        <= in_bytes[3:0];
      out_ra        <= ra_c;
      out_rb        <= rb_c;
      out_const     <= c_c;
      out_next_pc   <= npc_c;
      out_len       <= shape.len;
      out_has_reg   <= shape.has_reg;
      out_has_const <= shape.has_const;
      out_bad       <= shape.bad;
    end
  end

  assert_strobe_R1: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  assert_idle_R1: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  assert_noreg_R3: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_has_reg) |-> (out_ra == REG_NONE && out_rb == REG_NONE));
  assert_noconst_R6: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_has_const) |-> (out_const == '0));
  assert_badshape_R8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_bad) |-> (!out_has_reg && !out_has_const && out_len == LEN_W'(1)));
  assert_npc_R7: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> (out_next_pc == $past(in_pc) + ADDR_W'(out_len)));
  assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(out_next_pc) && $stable(out_const) && $stable(out_op)));
endmodule

// File: tb/sim_ifetch_splitter.sv
module sim_ifetch_splitter;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [31:0] in_pc = '0;
  logic [47:0] in_bytes = '0;
  logic        out_valid, out_has_reg, out_has_const, out_bad;
  logic [3:0]  out_op, out_fn, out_ra, out_rb;
  logic [31:0] out_const, out_next_pc;
  logic [2:0]  out_len;

  always #5 clk = ~clk;

  ifetch_splitter u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_pc(in_pc), .in_bytes(in_bytes),
    .out_valid(out_valid), .out_op(out_op), .out_fn(out_fn), .out_ra(out_ra),
    .out_rb(out_rb), .out_const(out_const), .out_next_pc(out_next_pc),
    .out_len(out_len), .out_has_reg(out_has_reg), .out_has_const(out_has_const),
    .out_bad(out_bad)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  logic [3:0]  e_op, e_fn, e_ra, e_rb;
  logic [31:0] e_const, e_npc;
  logic [2:0]  e_len;
  logic        e_hr, e_hc, e_bad;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] byt(input logic [47:0] w, input int k);
    return w[k*8 +: 8];
  endfunction

  task automatic model(input logic [31:0] pc, input logic [47:0] w);
    e_op = w[7:4];
    e_fn = w[3:0];
    e_hr = (e_op == 4'h2 || e_op == 4'h3 || e_op == 4'h4 || e_op == 4'h5 ||
            e_op == 4'h6 || e_op == 4'hA || e_op == 4'hB);
    e_hc = (e_op == 4'h3 || e_op == 4'h4 || e_op == 4'h5 || e_op == 4'h7 || e_op == 4'h8);
    e_bad = (e_op >= 4'hC);
    e_ra = e_hr ? byt(w, 1) >> 4 : 4'hF;
    e_rb = e_hr ? byt(w, 1) & 8'h0F : 4'hF;
    if (!e_hc) e_const = 32'h0;
    else if (e_hr) e_const = {byt(w, 5), byt(w, 4), byt(w, 3), byt(w, 2)};
    else e_const = {byt(w, 4), byt(w, 3), byt(w, 2), byt(w, 1)};
    if (e_hr && e_hc) e_len = 3'd6;
    else if (e_hc) e_len = 3'd5;
    else if (e_hr) e_len = 3'd2;
    else e_len = 3'd1;
    e_npc = pc + {29'd0, e_len};
  endtask

  task automatic check_all(input string ctx);
    chk({ctx, " R1 valid"}, {31'd0, out_valid}, 32'd1);
    chk({ctx, " R2 op"}, {28'd0, out_op}, {28'd0, e_op});
    chk({ctx, " R2 fn"}, {28'd0, out_fn}, {28'd0, e_fn});
    chk({ctx, " R3 has_reg"}, {31'd0, out_has_reg}, {31'd0, e_hr});
    chk({ctx, " R3 ra"}, {28'd0, out_ra}, {28'd0, e_ra});
    chk({ctx, " R3 rb"}, {28'd0, out_rb}, {28'd0, e_rb});
    chk({ctx, " R4/R5 has_const"}, {31'd0, out_has_const}, {31'd0, e_hc});
    chk({ctx, " R4/R5/R6 const"}, out_const, e_const);
    chk({ctx, " R7 len"}, {29'd0, out_len}, {29'd0, e_len});
    chk({ctx, " R7 next_pc"}, out_next_pc, e_npc);
    chk({ctx, " R8 bad"}, {31'd0, out_bad}, {31'd0, e_bad});
  endtask

  task automatic send(input string ctx, input logic [31:0] pc, input logic [47:0] w);
    @(negedge clk);
    in_valid = 1'b1;
    in_pc = pc;
    in_bytes = w;
    model(pc, w);
    @(posedge clk);
    #2;
    check_all(ctx);
  endtask

  task automatic idle_check(input logic [31:0] pc, input logic [47:0] w);
    @(negedge clk);
    in_valid = 1'b0;
    in_pc = pc;
    in_bytes = w;
    @(posedge clk);
    #2;
    chk("R1 idle strobe low", {31'd0, out_valid}, 32'd0);
    chk("R9 hold next_pc", out_next_pc, e_npc);
    chk("R9 hold const", out_const, e_const);
    chk("R9 hold op", {28'd0, out_op}, {28'd0, e_op});
    chk("R9 hold ra", {28'd0, out_ra}, {28'd0, e_ra});
    chk("R9 hold bad", {31'd0, out_bad}, {31'd0, e_bad});
  endtask

  initial begin : watchdog
    for (int i = 0; i < 100000; i++) begin
      @(posedge clk);
      if (done) disable watchdog;
    end
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(posedge clk);
    #2;
    // R10: reset state before any window is accepted
    chk("R10 valid", {31'd0, out_valid}, 32'd0);
    chk("R10 ra", {28'd0, out_ra}, 32'hF);
    chk("R10 rb", {28'd0, out_rb}, 32'hF);
    chk("R10 const", out_const, 32'd0);
    chk("R10 next_pc", out_next_pc, 32'd0);
    chk("R10 len", {29'd0, out_len}, 32'd0);
    chk("R10 bad", {31'd0, out_bad}, 32'd0);
    chk("R10 op", {28'd0, {out_op}}, 32'd0);
    chk("R10 flags", {30'd0, out_has_reg, out_has_const}, 32'd0);

    // Directed: one window for every operation class
    for (int op = 0; op < 16; op++) begin
      send("dir-class", 32'h0000_1000 + 32'(op * 16),
           {40'hA1B2_C3D4_E5, 4'(op), 4'h3});
    end
    // R4 jump constant at bytes 1..4
    send("R4 jcc", 32'h0000_0100, 48'hFF_DEAD_BEEF_74);
    // R5 constant at bytes 2..5
    send("R5 irmov", 32'h0000_0200, 48'h1234_5678_F2_30);
    // R7 wrap of next address
    send("R7 wrap", 32'hFFFF_FFFE, 48'h8899_AABB_CC_50);
    send("R7 wrap call", 32'hFFFF_FFFF, 48'h0011_2233_44_80);
    // R8 undefined classes
    send("R8 undef", 32'h0000_0300, 48'h1122_3344_55_C0);
    send("R8 undef F", 32'h0000_0304, 48'hFFFF_FFFF_FF_FF);
    // R9 hold with a different window offered but not valid
    idle_check(32'h0BAD_0000, 48'h0102_0304_05_30);
    idle_check(32'h0000_0000, 48'h0);
    // Back-to-back windows
    send("R1 b2b a", 32'h0000_0400, 48'h0000_0000_01_60);
    send("R1 b2b b", 32'h0000_0402, 48'h0000_0000_23_A0);

    for (int i = 0; i < 400; i++) begin
      logic [47:0] w;
      w = {$urandom, $urandom} [47:0];
      if (($urandom % 4) == 0) begin
        idle_check($urandom, w);
      end else begin
        send("rand", $urandom, w);
      end
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule